// File: doc/BRIEF.md
# Byte-Wide UV-Erasable Memory Mode Controller

This block is a synthesizable, clocked behavioural model of a byte-wide memory that can only be written by clearing bits. It looks at a chip-select, an output-enable pin and two flags that stand for the high voltages a real part would see. The first flag marks the output-enable line raised to programming voltage. The second marks the identifier voltage on address line nine. From these it decodes seven operating modes: read, output disable, standby, program, program inhibit, verify (which is a read after programming) and identifier readout.

The storage is a small array of bytes, sized by a parameter. Reset plays the role of an ultraviolet erase: every byte returns to all ones. A program pulse stores the old byte ANDed with the data inputs, so a bit that has been cleared stays at zero until the next reset. The output is registered. Values appear on `dout` with `dout_en` high one clock after the inputs that select them are sampled. When `dout_en` is low, `dout` is 00h. All pins are plain control and data levels. The block has no handshake and no back-pressure, because the device it models has none.

Top module: `eprom_mode_ctl`

## Requirements
- R1: After reset every byte reads FFh, and `dout_en` is 0 until a read or identifier mode is sampled.
- R2: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `a9_hi`=0 sampled at a clock edge, `dout_en` is 1 after that edge and `dout` is the byte stored at `addr`.
- R3: With `ce_n`=0, `vpp_hi`=0 and `oe_n`=1 sampled, `dout_en` is 0 and `dout` is 00h after the edge.
- R4: With `ce_n`=1 and `vpp_hi`=0 sampled, `dout_en` is 0 and `dout` is 00h after the edge, whatever `oe_n` is.
- R5: A write happens only at the first edge that samples `ce_n`=0 and `vpp_hi`=1 after an edge that sampled `ce_n`=1. A pulse of any length writes once. `vpp_hi` rising while `ce_n` is already 0 writes nothing. While `vpp_hi`=1 and `ce_n`=0, the outputs are off, whatever `oe_n` is.
- R6: A write stores (old byte AND `din`). A second write to the same address never turns a 0 bit back to 1.
- R7: With `ce_n`=1 and `vpp_hi`=1 sampled, nothing is written and the outputs are off.
- R8: A read after a write returns the programmed value.
- R9: In identifier mode (`ce_n`=0, `oe_n`=0, `vpp_hi`=0, `a9_hi`=1), when every address bit other than bit 0 and bit 9 is 0, the output is C2h for `addr[0]`=0 and 02h for `addr[0]`=1. Both bytes have odd parity, with bit 7 as the parity bit.
- R10: In identifier mode with any address bit other than bit 0 or bit 9 set, the output is FFh with `dout_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Active-low asynchronous reset, acts as erase |
| ce_n | input | 1 | Chip select, active low; also the program pulse |
| oe_n | input | 1 | Output enable at logic level, active low |
| vpp_hi | input | 1 | Output-enable line held at programming voltage |
| a9_hi | input | 1 | Identifier voltage present on address line nine |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data to program |
| dout | output | 8 | Registered read data, 00h when not driven |
| dout_en | output | 1 | Output driver enable (0 means high impedance) |

## Verification
The hardest case to reach from the ports is the difference between a real program pulse and a chip select that was already low when the programming voltage appeared. Only the first one may change the array. The stimulus holds `ce_n` low with outputs disabled and then raises `vpp_hi`. A later read of that address must still return FFh. This is set against normal pulses of several cycles, which must write exactly once. The inhibit case and the identifier path with a stray address bit are also driven, and each is followed by a readback at the ports.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_INHIBIT,
    MD_PROGRAM,
    MD_DISABLE,
    MD_READ,
    MD_IDENT
  } mode_e;

  localparam logic [7:0] BLANK_BYTE = 8'hFF;
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  vpp_hi,
  input  logic  a9_hi,
  output mode_e mode,
  output logic  prog_stb
);
  logic ce_q;

  always_comb begin
    if (ce_n)        mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
    else if (vpp_hi) mode = MD_PROGRAM;
    else if (oe_n)   mode = MD_DISABLE;
    else if (a9_hi)  mode = MD_IDENT;
    else             mode = MD_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_q <= 1'b1;
    else        ce_q <= ce_n;
  end

  assign prog_stb = (mode == MD_PROGRAM) && ce_q;

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |=> !prog_stb); // R5
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array
  import eprom_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= BLANK_BYTE;
    end else if (wr_en) begin
      cells[addr] <= cells[addr] & wr_data;
    end
  end

  assign rd_data = cells[addr];

  AST_BITS_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((cells[$past(addr)] & ~$past(rd_data)) == 8'h00)); // R6
endmodule

// File: rtl/eprom_out_stage.sv
module eprom_out_stage
  import eprom_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter logic [7:0]  MFR_ID = 8'hC2,
  parameter logic [7:0]  DEV_ID = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        rd_data,
  output logic [7:0]        dout,
  output logic              dout_en
);
  function automatic logic [ADDR_W-1:0] build_mask();
    logic [ADDR_W-1:0] m;
    for (int i = 0; i < ADDR_W; i++) m[i] = (i != 0) && (i != 9);
    return m;
  endfunction

  localparam logic [ADDR_W-1:0] OTHER_MASK = build_mask();

  logic       id_legal;
  logic [7:0] nxt_d;
  logic       nxt_en;

  assign id_legal = (addr & OTHER_MASK) == '0;

  always_comb begin
    nxt_d  = 8'h00;
    nxt_en = 1'b0;
    case (mode)
      MD_READ: begin
        nxt_d  = rd_data;
        nxt_en = 1'b1;
      end
      MD_IDENT: begin
        nxt_en = 1'b1;
        if (id_legal) nxt_d = addr[0] ? DEV_ID : MFR_ID;
        else          nxt_d = BLANK_BYTE;
      end
      default: begin
        nxt_d  = 8'h00;
        nxt_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= 8'h00;
      dout_en <= 1'b0;
    end else begin
      dout    <= nxt_d;
      dout_en <= nxt_en;
    end
  end

  AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_IDENT && id_legal) |=> (dout_en && (^dout))); // R9
  AST_ID_ILLEGAL_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_IDENT && !id_legal) |=> (dout_en && dout == 8'hFF)); // R10
endmodule

// File: rtl/eprom_mode_ctl.sv
module eprom_mode_ctl
  import eprom_pkg::*;
#(
  parameter int         DEPTH  = 256,
  parameter logic [7:0] MFR_ID = 8'hC2,
  parameter logic [7:0] DEV_ID = 8'h02,
  localparam int        ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              a9_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);
  mode_e      mode;
  logic       prog_stb;
  logic [7:0] rd_data;

  eprom_mode_dec u_dec (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
    .vpp_hi(vpp_hi), .a9_hi(a9_hi), .mode(mode), .prog_stb(prog_stb)
  );

  eprom_cell_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(prog_stb), .addr(addr),
    .wr_data(din), .rd_data(rd_data)
  );

  eprom_out_stage #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr),
    .rd_data(rd_data), .dout(dout), .dout_en(dout_en)
  );

  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ce_n) && !$past(vpp_hi)) |-> (!dout_en && dout == 8'h00)); // R4
  AST_DISABLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ce_n) && $past(oe_n) && !$past(vpp_hi)) |-> !dout_en); // R3
  AST_PROG_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vpp_hi) |-> !dout_en); // R7
endmodule

// File: tb/eprom_mode_ctl_tb_top.sv
`timescale 1ns/1ps
module eprom_mode_ctl_tb_top;
  localparam int DEPTH = 256;
  localparam int AW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, a9_hi = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = 8'hFF;
  logic [7:0] dout;
  logic dout_en;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  eprom_mode_ctl #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .a9_hi(a9_hi), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h (en,data)", tag, act, exp);
    end
  endtask

  // behavioural reference, one step per clock
  logic [7:0] mm [DEPTH];
  bit   m_ceq;
  bit   e_en, e_valid;
  logic [7:0] e_d;
  string e_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mm[i] = 8'hFF;
      m_ceq = 1; e_en = 0; e_d = 8'h00; e_valid = 0; e_tag = "R1";
    end else begin
      e_en = 0; e_d = 8'h00;
      if (ce_n) begin
        e_tag = vpp_hi ? "R7" : "R4";
      end else if (vpp_hi) begin
        e_tag = "R5";
        if (m_ceq) mm[addr] = mm[addr] & din;
      end else if (oe_n) begin
        e_tag = "R3";
      end else if (a9_hi) begin
        e_en = 1;
        if ((addr >> 1) == 0) begin
          e_d = addr[0] ? 8'h02 : 8'hC2; e_tag = "R9";
        end else begin
          e_d = 8'hFF; e_tag = "R10";
        end
      end else begin
        e_en = 1; e_d = mm[addr]; e_tag = "R2";
      end
      m_ceq = ce_n;
      e_valid = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && e_valid)
      check(dout_en == e_en && dout == e_d, e_tag, {dout_en, dout}, {e_en, e_d});
  end

  task automatic do_read(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    ce_n = 0; oe_n = 0; vpp_hi = 0; a9_hi = 0; addr = a;
    @(negedge clk); #1;
    check(dout_en && dout == exp, tag, {dout_en, dout}, {1'b1, exp});
  endtask

  task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 1; oe_n = 1; a9_hi = 0; vpp_hi = 1; addr = a; din = d;
    @(negedge clk); ce_n = 0;
    repeat (3) @(negedge clk);
    ce_n = 1;
    @(negedge clk); vpp_hi = 0; din = 8'hFF;
  endtask

  task automatic do_ident(input logic [AW-1:0] a);
    @(negedge clk);
    ce_n = 0; oe_n = 0; vpp_hi = 0; a9_hi = 1; addr = a;
    @(negedge clk);
    a9_hi = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; check(!dout_en && dout == 8'h00, "R1", {dout_en, dout}, 9'h000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1: blank array reads all ones
    for (int i = 0; i < 8; i++) do_read(AW'(i * 37), 8'hFF, "R1");
    // R3 and R4: output disable and standby with oe low
    @(negedge clk); ce_n = 0; oe_n = 1;
    repeat (2) @(negedge clk); ce_n = 1; oe_n = 0;
    repeat (2) @(negedge clk); oe_n = 1;
    // R8: program then verify
    do_prog(8'd3, 8'hA5);
    do_read(8'd3, 8'hA5, "R8");
    // R6: second write cannot raise bits
    do_prog(8'd5, 8'hF0);
    do_prog(8'd5, 8'h3C);
    do_read(8'd5, 8'h30, "R6");
    do_prog(8'd5, 8'hFF);
    do_read(8'd5, 8'h30, "R6");
    // R5: vpp raised while chip select already low writes nothing
    @(negedge clk); ce_n = 0; oe_n = 1; addr = 8'd9; din = 8'h00;
    @(negedge clk); vpp_hi = 1; oe_n = 0;
    repeat (3) @(negedge clk); vpp_hi = 0; oe_n = 1;
    @(negedge clk); ce_n = 1;
    do_read(8'd9, 8'hFF, "R5");
    // R7: inhibit leaves array unchanged
    @(negedge clk); ce_n = 1; vpp_hi = 1; addr = 8'd3; din = 8'h00;
    for (int i = 0; i < 4; i++) begin @(negedge clk); addr = AW'(3 + i); end
    vpp_hi = 0;
    do_read(8'd3, 8'hA5, "R7");
    do_read(8'd4, 8'hFF, "R7");
    // R9 and R10: identifier bytes
    do_ident(8'h00);
    do_ident(8'h01);
    do_ident(8'h02);
    do_ident(8'h81);
    do_ident(8'h00);
    // sweep of programmed and blank reads, R2
    do_prog(8'hFF, 8'h5A);
    for (int i = 250; i < 256; i++) do_read(AW'(i), (i == 255) ? 8'h5A : 8'hFF, "R2");
    @(negedge clk); ce_n = 1; oe_n = 1;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule